// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output toward a processor. It holds a pending-request set, an in-service set and a mask, resolves which pending level wins, and hands the processor an 8-bit vector when the processor acknowledges. Service of a level ends through an end-of-interrupt (EOI) command. The command names a level (specific) or retires the highest-priority level in service (non-specific). In automatic mode the in-service bit is never kept.

Each input can be edge or level sensitive. Priority is either fixed, with level 0 the highest, or rotating, where a level drops to lowest once its service ends. Four write-only configuration slots hold the mask, the trigger mode, the vector base with the mode bits, and the EOI command. If the processor acknowledges when no eligible request remains, the block answers with the level-7 vector and records nothing as in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_out` and `vec_valid` are 0, `vec_out` is 0, mask, trigger mode and vector base are 0, and priority is fixed with automatic EOI off.
- R2: An edge-mode input (trigger bit 0) is latched on a 0-to-1 transition. The latch clears if the input returns to 0 before the acknowledge. An acknowledge consumes it, so a line that stays high does not request again.
- R3: A level-mode input (trigger bit 1, written at slot 1) requests for as long as it is high, including again after its service ends.
- R4: A mask bit at 1 (slot 0, bit i for input i) keeps input i from raising `int_out` or winning an acknowledge. The latched edge survives, and it requests once unmasked.
- R5: `ack` held for one cycle gives `vec_valid` high for exactly the next cycle. `vec_out` then equals the vector base (slot 2, bits 7:3) with bits 2:0 set to the winning level. In fixed priority, level 0 is the highest.
- R6: `int_out` is high only when an unmasked pending level has strictly higher priority than every level in service. A winning acknowledge marks its level in service.
- R7: A write to slot 3 with bit 3 = 0 (non-specific EOI) clears the highest-priority level in service.
- R8: A write to slot 3 with bit 3 = 1 (specific EOI) clears the in-service bit of level bits 2:0 and no other.
- R9: With automatic EOI (slot 2 bit 1 = 1), an acknowledge leaves no level in service.
- R10: With rotating priority (slot 2 bit 0 = 1), the level whose service ends becomes lowest priority, and the next level up becomes highest. Writing slot 2 restarts the order at level 0 highest.
- R11: An acknowledge with no eligible request returns the vector base with bits 2:0 = 7 and does not mark level 7 in service.
- R12: An acknowledge and an EOI in the same cycle both take effect. The EOI acts on the in-service set as it stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, bit i is level i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Slot: 0 mask, 1 trigger, 2 base/mode, 3 EOI |
| cfg_wdata | input | 8 | Configuration write data |
| ack | input | 1 | Acknowledge, one cycle per vector |
| int_out | output | 1 | Interrupt toward the processor |
| vec_valid | output | 1 | Vector present on `vec_out` |
| vec_out | output | 8 | Acknowledge vector |

## Verification
An acknowledge and an EOI command can land in the same clock cycle. The EOI retires the old top level while the acknowledge installs a new, higher one. The bench provokes this by holding level 1 in service, raising level 0, and then asserting `ack` together with a non-specific EOI write. It checks that the vector names level 0. It then shows that level 1 really left service: a fresh edge on input 1 raises `int_out` once level 0 is retired.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    irq_in,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [VW-1:0] cfg_wdata,
  input  logic          ack,
  output logic          int_out,
  output logic          vec_valid,
  output logic [VW-1:0] vec_out
);
  localparam int LVLS = 8;
  localparam int LW   = $clog2(LVLS);

  logic [LVLS-1:0] mask_r, lvl_r, irq_d, edge_r, isr_r;
  logic [VW-LW-1:0] base_r;
  logic             rot_r, aeoi_r;
  logic [LW-1:0]    low_r, eff_low;

  logic [LVLS-1:0] req;
  logic            req_hit, isr_hit, grant;
  logic [LW-1:0]   req_lvl, req_rank, isr_lvl, isr_rank;

  logic            eoi_we, eoi_do;
  logic [LW-1:0]   eoi_lvl;
  logic [LVLS-1:0] edge_nx, isr_nx;

  assign eff_low = rot_r ? low_r : LW'(LVLS-1);
  assign req     = ((lvl_r & irq_in) | (~lvl_r & edge_r)) & ~mask_r;

  always_comb begin
    req_hit = 1'b0; req_lvl = '0; req_rank = '0;
    isr_hit = 1'b0; isr_lvl = '0; isr_rank = '0;
    for (int k = LVLS-1; k >= 0; k--) begin
      if (req[LW'(int'(eff_low) + k + 1)]) begin
        req_hit  = 1'b1;
        req_lvl  = LW'(int'(eff_low) + k + 1);
        req_rank = LW'(k);
      end
      if (isr_r[LW'(int'(eff_low) + k + 1)]) begin
        isr_hit  = 1'b1;
        isr_lvl  = LW'(int'(eff_low) + k + 1);
        isr_rank = LW'(k);
      end
    end
  end

  assign grant   = req_hit && (!isr_hit || req_rank < isr_rank);
  assign int_out = grant;

  assign eoi_we  = cfg_we && cfg_addr == 2'd3;
  assign eoi_lvl = cfg_wdata[3] ? cfg_wdata[LW-1:0] : isr_lvl;
  assign eoi_do  = eoi_we && (cfg_wdata[3] ? isr_r[eoi_lvl] : isr_hit);

  always_comb begin
    edge_nx = (edge_r | (irq_in & ~irq_d)) & irq_in;
    isr_nx  = isr_r;
    if (eoi_do) isr_nx[eoi_lvl] = 1'b0;
    if (ack && grant) begin
      edge_nx[req_lvl] = 1'b0;
      if (!aeoi_r) isr_nx[req_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r <= '0; lvl_r <= '0; irq_d <= '0; edge_r <= '0; isr_r <= '0;
      base_r <= '0; rot_r <= 1'b0; aeoi_r <= 1'b0; low_r <= LW'(LVLS-1);
      vec_valid <= 1'b0; vec_out <= '0;
    end else begin
      irq_d  <= irq_in;
      edge_r <= edge_nx;
      isr_r  <= isr_nx;
      if (cfg_we && cfg_addr == 2'd0) mask_r <= cfg_wdata[LVLS-1:0];
      if (cfg_we && cfg_addr == 2'd1) lvl_r  <= cfg_wdata[LVLS-1:0];
      if (cfg_we && cfg_addr == 2'd2) begin
        base_r <= cfg_wdata[VW-1:LW];
        aeoi_r <= cfg_wdata[1];
        rot_r  <= cfg_wdata[0];
        low_r  <= LW'(LVLS-1);
      end else if (rot_r) begin
        if (eoi_do) low_r <= eoi_lvl;
        if (ack && grant && aeoi_r) low_r <= req_lvl;
      end
      vec_valid <= ack;
      if (ack) vec_out <= {base_r, grant ? req_lvl : LW'(LVLS-1)};
    end
  end

  // R5
  vld_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);
  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);
  // R11
  spur_no_isr7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !grant |=> vec_out[LW-1:0] == '1 && !(isr_r[LVLS-1] && !$past(isr_r[LVLS-1])));
  // R9
  aeoi_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi_r && ack && !eoi_we |=> $countones(isr_r) == $countones($past(isr_r)));
  // R7
  eoi_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we && !ack |=> $countones(isr_r) <= $countones($past(isr_r)));
  // R6
  ack_marks_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && int_out && !aeoi_r && !eoi_we |=> $countones(isr_r) == $countones($past(isr_r)) + 1);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       ack = 1'b0;
  logic       int_out, vec_valid;
  logic [7:0] vec_out;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack(ack),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_irq(logic [7:0] v);
    irq_in = v; @(negedge clk);
  endtask

  task automatic cfg(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_ack(string tag, logic [7:0] exp_vec);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk({tag, " vector"}, int'(vec_out), int'(exp_vec));
    chk({tag, " valid"}, int'(vec_valid), 1);
  endtask

  task automatic t_reset();
    chk("R1 int_out", int'(int_out), 0);
    chk("R1 vec_valid", int'(vec_valid), 0);
    chk("R1 vec_out", int'(vec_out), 0);
  endtask

  task automatic t_fixed_nest();
    cfg(2'd2, 8'h40);
    set_irq(8'h28);
    chk("R2 edge latched", int'(int_out), 1);
    do_ack("R5 level3", 8'h43);
    @(negedge clk);
    chk("R5 valid one cycle", int'(vec_valid), 0);
    chk("R6 lower blocked", int'(int_out), 0);
    set_irq(8'h2A);
    chk("R6 higher nests", int'(int_out), 1);
    do_ack("R6 level1", 8'h41);
    chk("R6 after nest", int'(int_out), 0);
    cfg(2'd3, 8'h00);
    chk("R7 first EOI leaves 3", int'(int_out), 0);
    cfg(2'd3, 8'h00);
    chk("R7 second EOI frees 5", int'(int_out), 1);
    do_ack("R5 level5", 8'h45);
    cfg(2'd3, 8'h0D);
    chk("R2 edge consumed", int'(int_out), 0);
    set_irq(8'h00);
  endtask

  task automatic t_spurious();
    set_irq(8'h10);
    chk("R2 edge 4", int'(int_out), 1);
    set_irq(8'h00);
    chk("R2 dropped before ack", int'(int_out), 0);
    do_ack("R11 spurious", 8'h47);
    set_irq(8'h80);
    chk("R11 isr7 not set", int'(int_out), 1);
    do_ack("R11 real level7", 8'h47);
    cfg(2'd3, 8'h0F);
    set_irq(8'h00);
  endtask

  task automatic t_level();
    cfg(2'd1, 8'h04);
    set_irq(8'h04);
    chk("R3 level request", int'(int_out), 1);
    do_ack("R3 level2", 8'h42);
    chk("R3 in service", int'(int_out), 0);
    cfg(2'd3, 8'h00);
    chk("R3 requests again", int'(int_out), 1);
    set_irq(8'h00);
    chk("R3 follows input", int'(int_out), 0);
    cfg(2'd1, 8'h00);
  endtask

  task automatic t_mask();
    cfg(2'd0, 8'h01);
    set_irq(8'h01);
    chk("R4 masked", int'(int_out), 0);
    do_ack("R4 masked ack spurious", 8'h47);
    cfg(2'd0, 8'h00);
    chk("R4 unmasked", int'(int_out), 1);
    do_ack("R4 level0", 8'h40);
    cfg(2'd3, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_specific();
    set_irq(8'h06);
    do_ack("R8 level1", 8'h41);
    chk("R8 level2 blocked", int'(int_out), 0);
    cfg(2'd3, 8'h0A);
    chk("R8 other level kept", int'(int_out), 0);
    cfg(2'd3, 8'h09);
    chk("R8 named cleared", int'(int_out), 1);
    do_ack("R8 level2", 8'h42);
    cfg(2'd3, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_auto();
    cfg(2'd2, 8'h42);
    set_irq(8'h09);
    do_ack("R9 level0", 8'h40);
    chk("R9 no in-service", int'(int_out), 1);
    do_ack("R9 level3", 8'h43);
    chk("R9 idle", int'(int_out), 0);
    set_irq(8'h00);
    cfg(2'd2, 8'h40);
  endtask

  task automatic t_rotate();
    cfg(2'd2, 8'h41);
    set_irq(8'h11);
    do_ack("R10 level0 first", 8'h40);
    cfg(2'd3, 8'h00);
    set_irq(8'h10);
    set_irq(8'h11);
    do_ack("R10 level4 beats 0", 8'h44);
    chk("R10 level0 lowest", int'(int_out), 0);
    cfg(2'd3, 8'h0C);
    chk("R10 level0 after rotate", int'(int_out), 1);
    do_ack("R10 level0", 8'h40);
    cfg(2'd3, 8'h00);
    set_irq(8'h00);
    cfg(2'd2, 8'h40);
  endtask

  task automatic t_same_cycle();
    set_irq(8'h02);
    do_ack("R12 level1", 8'h41);
    set_irq(8'h03);
    chk("R12 level0 nests", int'(int_out), 1);
    ack = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'h00;
    @(negedge clk);
    ack = 1'b0; cfg_we = 1'b0;
    chk("R12 vector", int'(vec_out), 8'h40);
    chk("R12 nothing pending", int'(int_out), 0);
    cfg(2'd3, 8'h00);
    set_irq(8'h01);
    set_irq(8'h03);
    chk("R12 level1 retired", int'(int_out), 1);
    do_ack("R12 level1 again", 8'h41);
    cfg(2'd3, 8'h00);
    set_irq(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed_nest();
    t_spurious();
    t_level();
    t_mask();
    t_specific();
    t_auto();
    t_rotate();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule